// File: doc/BRIEF.md
# Delay-Lock Bias Controller

This block closes a digital bang-bang loop that holds the delay of a reference logic path at one period of an external beat clock. The reference path has an active-low completion signal. The signal goes high (precharged) at the start of each evaluation and falls once every output of the path has settled. On each rising edge of the beat clock, the controller notes whether completion has already fallen. If it has, the path is fast. If it has not, the path is slow.

A slow path brings a one-cycle up strobe, and the shared bias code steps up by one. Forward bias makes the logic quicker. A fast path brings a one-cycle down strobe, and the code steps back toward zero. The code never goes below zero, so forward bias is the only direction of correction. One reference path sets the bias for a whole cluster of logic, so the block has a single shared bias code.

Both asynchronous inputs pass through the same synchronizer chain. Their relative timing is therefore kept, and the decision is made inside the clk domain.

Top module: `dlock_bias_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, bias_code_o is 0 and both pump_up_o and pump_dn_o are 0. The reset is asynchronous.
- R2: If completion_ni is high when a rising edge of beat_clk_i is sampled, the path is slow. pump_up_o is then high for exactly one clk cycle. With the default of 2 synchronizer stages, it is visible after the third clk rising edge, counted from the edge that first samples beat_clk_i high.
- R3: If completion_ni is low when a rising edge of beat_clk_i is sampled, the path is fast. pump_dn_o is then high for exactly one clk cycle, with the same latency as in R2.
- R4: Each beat_clk_i rising edge gives exactly one strobe, either up or down, never both. In every other cycle both strobes are 0 and bias_code_o holds its value.
- R5: On the edge that raises pump_up_o, bias_code_o becomes its previous value plus one. It saturates at 63.
- R6: On the edge that raises pump_dn_o, bias_code_o becomes its previous value minus one. At 0 it stays at 0.
- R7: Consider a path whose delay falls by one clk cycle per bias step. Once the loop has settled, bias_code_o alternates between the two adjacent codes on either side of the point where completion lands on the beat edge.
- R8: After a step change in the path delay, the loop settles on the new pair of codes. It moves by one code per beat period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| beat_clk_i | input | 1 | External beat clock, asynchronous to clk_i |
| completion_ni | input | 1 | Active-low completion of the reference path |
| pump_up_o | output | 1 | One-cycle strobe: add forward bias |
| pump_dn_o | output | 1 | One-cycle strobe: relax bias toward zero |
| bias_code_o | output | 6 | Shared bias code, 0 means zero bias |

## Verification
The hardest state to reach from the ports is the steady dither. Each bias step must move completion across the beat edge, and this only happens when the path delay depends on the code the block itself drives. The bench therefore closes the loop with a delay model that reads bias_code_o and places the fall of completion_ni some clk cycles after precharge. That number is an offset minus the bias code.

The bench then changes the offset:
- It moves the offset up and down to force re-settling.
- It pushes the offset far above the reachable range, which drives the code into the ceiling.
- It pushes the offset far below that range, which parks the code on the floor.

// File: rtl/dlock_pkg.sv
package dlock_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'b00,
    REQ_UP   = 2'b01,
    REQ_DN   = 2'b10
  } pump_req_e;
endpackage

// File: rtl/dlock_sync.sv
module dlock_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stg_q <= '0;
        end else begin
          for (int i = STAGES - 1; i > 0; i--) stg_q[i] <= stg_q[i-1];
          stg_q[0] <= d_i;
        end
      end
      assign q_o = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dlock_phase_det.sv
module dlock_phase_det
  import dlock_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      beat_i,
  input  logic      comp_ni,
  output pump_req_e req_o
);
  logic beat_q;
  logic rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_q <= 1'b0;
    else         beat_q <= beat_i;
  end

  assign rise = beat_i & ~beat_q;

  // completion still high at the beat edge: path is late
  always_comb begin
    req_o = REQ_NONE;
    if (rise) req_o = comp_ni ? REQ_UP : REQ_DN;
  end

  // R4
  single_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o != REQ_NONE) |=> (req_o == REQ_NONE));
endmodule

// File: rtl/dlock_bias_reg.sv
module dlock_bias_reg
  import dlock_pkg::*;
#(
  parameter int BIAS_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pump_req_e         req_i,
  output logic              pump_up_o,
  output logic              pump_dn_o,
  output logic [BIAS_W-1:0] bias_o
);
  localparam logic [BIAS_W-1:0] BIAS_MAX = '1;

  logic [BIAS_W-1:0] bias_q;
  logic              up_q, dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bias_q <= '0;
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
    end else begin
      up_q <= (req_i == REQ_UP);
      dn_q <= (req_i == REQ_DN);
      case (req_i)
        REQ_UP:  if (bias_q != BIAS_MAX) bias_q <= bias_q + 1'b1;
        REQ_DN:  if (bias_q != '0)       bias_q <= bias_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign pump_up_o = up_q;
  assign pump_dn_o = dn_q;
  assign bias_o    = bias_q;

  // R4
  one_pump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_q && dn_q));

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bias_q != $past(bias_q)) |-> (up_q || dn_q));

  // R5
  ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && $past(bias_q) == BIAS_MAX) |-> (bias_q == BIAS_MAX));

  // R6
  floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_q && $past(bias_q) == '0) |-> (bias_q == '0));
endmodule

// File: rtl/dlock_bias_ctrl.sv
module dlock_bias_ctrl
  import dlock_pkg::*;
#(
  parameter int BIAS_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_clk_i,
  input  logic              completion_ni,
  output logic              pump_up_o,
  output logic              pump_dn_o,
  output logic [BIAS_W-1:0] bias_code_o
);
  logic [1:0] sync_q;
  pump_req_e  req;

  // both inputs share one chain so their relative timing is kept
  dlock_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({beat_clk_i, completion_ni}),
    .q_o   (sync_q)
  );

  dlock_phase_det u_pd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .beat_i (sync_q[1]),
    .comp_ni(sync_q[0]),
    .req_o  (req)
  );

  dlock_bias_reg #(.BIAS_W(BIAS_W)) u_bias (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .pump_up_o(pump_up_o),
    .pump_dn_o(pump_dn_o),
    .bias_o   (bias_code_o)
  );

  // R2
  up_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pump_up_o |=> !pump_up_o);

  // R3
  dn_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pump_dn_o |=> !pump_dn_o);
endmodule

// File: tb/dlock_bias_ctrl_test.sv
module dlock_bias_ctrl_test;
  localparam int P    = 16;
  localparam int LAT  = 3;
  localparam int BMAX = 63;
  localparam int THR  = P - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       beat = 1'b0;
  logic       comp_n = 1'b1;
  logic       pump_up, pump_dn;
  logic [5:0] bias;

  int n_chk = 0, n_bad = 0;
  int d0 = 44;
  int dly = 0;
  int bias_prev = 0;
  bit slow_lat = 1'b0;
  int cyc = 0;

  dlock_bias_ctrl uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .beat_clk_i   (beat),
    .completion_ni(comp_n),
    .pump_up_o    (pump_up),
    .pump_dn_o    (pump_dn),
    .bias_code_o  (bias)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 150000);
        summary();
      end
    end
  end

  // closed-loop run: check outputs, then drive beat and the delay model
  task automatic run_periods(input int n);
    int exp;
    for (int p = 0; p < n; p++) begin
      for (int c = 0; c < P; c++) begin
        @(negedge clk);
        if (c == LAT) begin
          chk(pump_up == slow_lat, slow_lat ? "R2 up" : "R3 up", int'(pump_up), int'(slow_lat));
          chk(pump_dn == !slow_lat, slow_lat ? "R2 dn" : "R3 dn", int'(pump_dn), int'(!slow_lat));
          if (slow_lat) exp = (bias_prev == BMAX) ? BMAX : bias_prev + 1;
          else          exp = (bias_prev == 0) ? 0 : bias_prev - 1;
          chk(int'(bias) == exp, slow_lat ? "R5" : "R6", int'(bias), exp);
        end else begin
          chk(!pump_up && !pump_dn, "R4 strobe", int'({pump_up, pump_dn}), 0);
          chk(int'(bias) == bias_prev, "R4 hold", int'(bias), bias_prev);
        end
        bias_prev = int'(bias);
        beat = (c < P / 2);
        if (c == 0) slow_lat = comp_n;
        if (c == 1) comp_n = 1'b1;
        if (c == 4) dly = (d0 > int'(bias)) ? d0 - int'(bias) : 0;
        if (c >= 4 && c - 1 >= dly) comp_n = 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(bias == 6'd0, "R1 bias", int'(bias), 0);
    chk(!pump_up && !pump_dn, "R1 pumps", int'({pump_up, pump_dn}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bias == 6'd0, "R1 bias after release", int'(bias), 0);
    bias_prev = 0;
  endtask

  task automatic t_lock(input int d, input int settle, input string req);
    int last;
    d0 = d;
    run_periods(settle);
    last = int'(bias);
    for (int k = 0; k < 4; k++) begin
      run_periods(1);
      chk(int'(bias) == d - THR || int'(bias) == d - THR + 1, req, int'(bias), d - THR);
      chk(int'(bias) - last == 1 || last - int'(bias) == 1, {req, " dither"}, int'(bias), last);
      last = int'(bias);
    end
  endtask

  task automatic t_ceiling();
    d0 = 200;
    run_periods(70);
    chk(bias == 6'd63, "R5 ceiling", int'(bias), BMAX);
  endtask

  task automatic t_floor();
    d0 = 5;
    run_periods(70);
    chk(bias == 6'd0, "R6 floor", int'(bias), 0);
  endtask

  task automatic t_reset_mid();
    d0 = 200;
    run_periods(2);
    @(negedge clk);
    rst_n = 1'b0;
    beat = 1'b0;
    comp_n = 1'b1;
    #1;
    chk(bias == 6'd0, "R1 async clear", int'(bias), 0);
    repeat (2) @(negedge clk);
    chk(!pump_up && !pump_dn, "R1 pumps mid", int'({pump_up, pump_dn}), 0);
    rst_n = 1'b1;
    bias_prev = 0;
  endtask

  initial begin
    t_reset();
    t_lock(44, 40, "R7");
    t_lock(54, 16, "R8 up step");
    t_lock(34, 26, "R8 down step");
    t_ceiling();
    t_floor();
    t_reset_mid();
    t_lock(30, 24, "R7 after reset");
    summary();
  end
endmodule